// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Alarm Match

This block keeps the time of day as six packed BCD digits: two each for seconds, minutes and hours. It runs from the system clock, but the time moves forward only on a one-cycle tick that arrives once per second. The seconds and minutes are chains of single-digit counters. A units stage counts modulo ten and a tens stage counts modulo six. Each stage is enabled by the wrap of the stage before it, so every flop shares one clock.

The hours pair runs in one of two modes. In 24-hour mode it counts 00 to 23. In 12-hour mode it counts 01 to 12, and a half-day flag flips on the step from 11 to 12. A new mode setting is used at the next hour step. If the hour is outside the range of the selected mode, the next tick forces it to that mode's first value.

Two BCD digits each give an alarm hour and an alarm minute. A combinational comparator raises the alarm output for the whole minute in which the registered hour and minute equal them.

Top module: `bcd_clock_core`

## Requirements
- R1: Seconds and minutes each count 00 to 59 in BCD. Each has a units digit that runs modulo 10 and a tens digit that runs modulo 6, and every digit value is 0 to 9.
- R2: The time and the half-day flag change only on a clock edge where `tick` is high. With `tick` low, every output digit and `pm` hold their values.
- R3: On a tick at seconds 59, the seconds go to 00 and the minutes advance by one.
- R4: On a tick at 59:59 (minutes:seconds), the minutes go to 00 and the hours advance.
- R5: With `mode12` = 0, the hours advance 00 to 23. From 23 they go to 00, with both digits cleared together. The tens digit advances only when the units digit wraps from 9 to 0 (09 to 10, 19 to 20).
- R6: With `mode12` = 1, the hours advance 01 to 12, and from 12 they go to 01, never to 00. The step 09 to 10 moves the tens digit.
- R7: In 12-hour mode, `pm` inverts when the hours step from 11 to 12, and only then.
- R8: Synchronous reset (`rst` high at a clock edge) sets the time to 00:00:00 when `mode12` = 0, or to 12:00:00 when `mode12` = 1, and clears `pm` in both cases.
- R9: With `mode12` = 1 and the hour at 00 or 13 to 23, the next tick sets the hour to 01. Seconds and minutes advance normally on that tick, and `pm` does not change.
- R10: `alarm` is high exactly when the alarm hour digits equal the hour digits and the alarm minute digits equal the minute digits. It depends only on the current registered time and the alarm inputs, so it stays high for the whole matching minute.
- R11: If any alarm digit is above 9, `alarm` stays low. For example, an alarm minute of tens 0 and units 0xA does not match a clock minute of 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle enable, once per second |
| mode12 | input | 1 | 1 = 12-hour mode, 0 = 24-hour mode |
| alarm_hr_t | input | 4 | Alarm hour, tens digit (BCD) |
| alarm_hr_u | input | 4 | Alarm hour, units digit (BCD) |
| alarm_min_t | input | 4 | Alarm minute, tens digit (BCD) |
| alarm_min_u | input | 4 | Alarm minute, units digit (BCD) |
| sec_t | output | 4 | Seconds tens digit |
| sec_u | output | 4 | Seconds units digit |
| min_t | output | 4 | Minutes tens digit |
| min_u | output | 4 | Minutes units digit |
| hr_t | output | 4 | Hours tens digit |
| hr_u | output | 4 | Hours units digit |
| pm | output | 1 | Half-day flag, flips on 11 to 12 in 12-hour mode |
| alarm | output | 1 | High while the hour and minute equal the alarm setting |

## Verification
The assertions assume the following about the inputs:
- `tick` is a clean one-cycle enable that is never X outside reset.
- `rst` is high on the first clock edge.
- `mode12` may change at any cycle, so the properties on the hour wraps read the mode in the same cycle as the step.

The stimulus drives every input half a period away from the rising edge. The main runs hold `tick` high on every cycle, so a full day and a half day fit in the run. The mode is changed only at points where the forced-hour rule is the behaviour under test. The alarm inputs change only between ticks.

// File: rtl/bcd_clock_pkg.sv
package bcd_clock_pkg;

  localparam int BCD_W     = 4;
  localparam int UNITS_MOD = 10;
  localparam int TENS_MOD  = 6;
  localparam int BIN_W     = 7;
  localparam int HR12_MIN  = 1;
  localparam int HR12_MAX  = 12;
  localparam int HR24_MAX  = 23;

  typedef logic [BCD_W-1:0] bcd_t;

  localparam bcd_t BCD_ZERO = bcd_t'(0);
  localparam bcd_t BCD_ONE  = bcd_t'(1);
  localparam bcd_t BCD_TWO  = bcd_t'(2);
  localparam bcd_t BCD_NINE = bcd_t'(9);

  // A digit is legal BCD when it does not exceed nine.
  function automatic logic bcd_valid(input bcd_t d);
    return d <= BCD_NINE;
  endfunction

  // Two BCD digits folded into a plain binary value.
  function automatic logic [BIN_W-1:0] bcd_to_bin(input bcd_t t, input bcd_t u);
    return BIN_W'(t) * BIN_W'(10) + BIN_W'(u);
  endfunction

  // Whether an hour pair is legal for the selected mode.
  function automatic logic hour_in_range(input logic m12, input bcd_t t, input bcd_t u);
    logic [BIN_W-1:0] v;
    v = bcd_to_bin(t, u);
    if (!bcd_valid(t) || !bcd_valid(u)) return 1'b0;
    if (m12) return (v >= BIN_W'(HR12_MIN)) && (v <= BIN_W'(HR12_MAX));
    return v <= BIN_W'(HR24_MAX);
  endfunction

  // Next hour pair on an hour carry; the result is {tens, units}.
  function automatic logic [2*BCD_W-1:0] hour_step(input logic m12, input bcd_t t, input bcd_t u);
    if (m12 && t == BCD_ONE && u == BCD_TWO) return {BCD_ZERO, BCD_ONE};
    if (!m12 && t == BCD_TWO && u == bcd_t'(3)) return {BCD_ZERO, BCD_ZERO};
    if (u == BCD_NINE) return {t + BCD_ONE, BCD_ZERO};
    return {t, u + BCD_ONE};
  endfunction

endpackage

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter #(
  parameter int MODULUS = 10,
  parameter int W       = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(MODULUS - 1);

  // Wrap is the enable handed to the next stage.
  assign wrap = en && (q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (wrap) q <= '0;
    else if (en)   q <= q + 1'b1;
  end
endmodule

// File: rtl/bcd_hour_counter.sv
module bcd_hour_counter
  import bcd_clock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic carry,
  input  logic mode12,
  output bcd_t hr_t,
  output bcd_t hr_u,
  output logic pm,
  output logic force_o,
  output logic pm_flip_o
);
  bcd_t nxt_t, nxt_u;
  logic in_range;

  always_comb begin
    in_range  = hour_in_range(mode12, hr_t, hr_u);
    force_o   = tick && !in_range;
    pm_flip_o = 1'b0;
    nxt_t     = hr_t;
    nxt_u     = hr_u;
    if (force_o) begin
      nxt_t = BCD_ZERO;
      nxt_u = mode12 ? BCD_ONE : BCD_ZERO;
    end else if (carry) begin
      {nxt_t, nxt_u} = hour_step(mode12, hr_t, hr_u);
      pm_flip_o      = mode12 && (hr_t == BCD_ONE) && (hr_u == BCD_ONE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hr_t <= mode12 ? BCD_ONE : BCD_ZERO;
      hr_u <= mode12 ? BCD_TWO : BCD_ZERO;
      pm   <= 1'b0;
    end else begin
      hr_t <= nxt_t;
      hr_u <= nxt_u;
      if (pm_flip_o) pm <= ~pm;
    end
  end
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_clock_pkg::*;
(
  input  bcd_t al_hr_t,
  input  bcd_t al_hr_u,
  input  bcd_t al_min_t,
  input  bcd_t al_min_u,
  input  bcd_t hr_t,
  input  bcd_t hr_u,
  input  bcd_t min_t,
  input  bcd_t min_u,
  output logic match
);
  logic setting_ok, hr_eq, min_eq;

  always_comb begin
    setting_ok = bcd_valid(al_hr_t) && bcd_valid(al_hr_u)
              && bcd_valid(al_min_t) && bcd_valid(al_min_u);
    hr_eq      = bcd_to_bin(al_hr_t, al_hr_u) == bcd_to_bin(hr_t, hr_u);
    min_eq     = bcd_to_bin(al_min_t, al_min_u) == bcd_to_bin(min_t, min_u);
    match      = setting_ok && hr_eq && min_eq;
  end
endmodule

// File: rtl/bcd_clock_core.sv
module bcd_clock_core
  import bcd_clock_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             mode12,
  input  logic [BCD_W-1:0] alarm_hr_t,
  input  logic [BCD_W-1:0] alarm_hr_u,
  input  logic [BCD_W-1:0] alarm_min_t,
  input  logic [BCD_W-1:0] alarm_min_u,
  output logic [BCD_W-1:0] sec_t,
  output logic [BCD_W-1:0] sec_u,
  output logic [BCD_W-1:0] min_t,
  output logic [BCD_W-1:0] min_u,
  output logic [BCD_W-1:0] hr_t,
  output logic [BCD_W-1:0] hr_u,
  output logic             pm,
  output logic             alarm
);
  localparam int NSTAGE = 4;

  // carry_chain[i] enables stage i; stage order is sec_u, sec_t, min_u, min_t.
  logic [NSTAGE:0]                 carry_chain;
  logic [NSTAGE-1:0][BCD_W-1:0]    digits;
  logic                            min_carry;
  logic                            hour_carry;
  logic                            hour_force;
  logic                            pm_toggle;

  assign carry_chain[0] = tick;

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    localparam int MOD = (i % 2 == 0) ? UNITS_MOD : TENS_MOD;
    bcd_digit_counter #(.MODULUS(MOD), .W(BCD_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .en   (carry_chain[i]),
      .q    (digits[i]),
      .wrap (carry_chain[i+1])
    );
  end

  assign min_carry  = carry_chain[2];
  assign hour_carry = carry_chain[NSTAGE];

  assign sec_u = digits[0];
  assign sec_t = digits[1];
  assign min_u = digits[2];
  assign min_t = digits[3];

  bcd_hour_counter u_hours (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .carry     (hour_carry),
    .mode12    (mode12),
    .hr_t      (hr_t),
    .hr_u      (hr_u),
    .pm        (pm),
    .force_o   (hour_force),
    .pm_flip_o (pm_toggle)
  );

  bcd_alarm_match u_alarm (
    .al_hr_t  (alarm_hr_t),
    .al_hr_u  (alarm_hr_u),
    .al_min_t (alarm_min_t),
    .al_min_u (alarm_min_u),
    .hr_t     (hr_t),
    .hr_u     (hr_u),
    .min_t    (min_t),
    .min_u    (min_u),
    .match    (alarm)
  );
endmodule

// File: rtl/bcd_clock_checker.sv
module bcd_clock_checker
  import bcd_clock_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic tick,
  input logic mode12,
  input bcd_t alarm_hr_t,
  input bcd_t alarm_hr_u,
  input bcd_t alarm_min_t,
  input bcd_t alarm_min_u,
  input bcd_t sec_t,
  input bcd_t sec_u,
  input bcd_t min_t,
  input bcd_t min_u,
  input bcd_t hr_t,
  input bcd_t hr_u,
  input logic pm,
  input logic alarm,
  input logic min_carry,
  input logic hour_carry,
  input logic hour_force
);
  p_digit_range_r1: assert property (@(posedge clk) disable iff (rst)
    sec_u <= 4'd9 && sec_t <= 4'd5 && min_u <= 4'd9 && min_t <= 4'd5 && hr_u <= 4'd9 && hr_t <= 4'd2);

  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable({sec_t, sec_u, min_t, min_u, hr_t, hr_u, pm}));

  p_min_carry_r3: assert property (@(posedge clk) disable iff (rst)
    min_carry |-> (tick && sec_t == 4'd5 && sec_u == 4'd9));

  p_sec_clear_r3: assert property (@(posedge clk) disable iff (rst)
    min_carry |=> (sec_t == 4'd0 && sec_u == 4'd0));

  p_hour_carry_r4: assert property (@(posedge clk) disable iff (rst)
    hour_carry |-> (min_carry && min_t == 4'd5 && min_u == 4'd9));

  p_wrap24_r5: assert property (@(posedge clk) disable iff (rst)
    (hour_carry && !mode12 && hr_t == 4'd2 && hr_u == 4'd3) |=> (hr_t == 4'd0 && hr_u == 4'd0));

  p_wrap12_r6: assert property (@(posedge clk) disable iff (rst)
    (hour_carry && !hour_force && mode12 && hr_t == 4'd1 && hr_u == 4'd2) |=> (hr_t == 4'd0 && hr_u == 4'd1));

  p_pm_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (hour_carry && !hour_force && mode12 && hr_t == 4'd1 && hr_u == 4'd1) |=> (pm != $past(pm)));

  p_pm_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(hour_carry && !hour_force && mode12 && hr_t == 4'd1 && hr_u == 4'd1) |=> $stable(pm));

  p_reset_time_r8: assert property (@(posedge clk)
    rst |=> (sec_t == 4'd0 && sec_u == 4'd0 && min_t == 4'd0 && min_u == 4'd0 && !pm));

  p_reset_hour_r8: assert property (@(posedge clk)
    rst |=> (hr_u == ($past(mode12) ? 4'd2 : 4'd0) && hr_t == ($past(mode12) ? 4'd1 : 4'd0)));

  p_force_r9: assert property (@(posedge clk) disable iff (rst)
    (hour_force && mode12) |=> (hr_t == 4'd0 && hr_u == 4'd1));

  p_alarm_equal_r10: assert property (@(posedge clk) disable iff (rst)
    alarm |-> (alarm_hr_t == hr_t && alarm_hr_u == hr_u && alarm_min_t == min_t && alarm_min_u == min_u));

  p_alarm_invalid_r11: assert property (@(posedge clk) disable iff (rst)
    (alarm_hr_t > 4'd9 || alarm_hr_u > 4'd9 || alarm_min_t > 4'd9 || alarm_min_u > 4'd9) |-> !alarm);
endmodule

bind bcd_clock_core bcd_clock_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .mode12      (mode12),
  .alarm_hr_t  (alarm_hr_t),
  .alarm_hr_u  (alarm_hr_u),
  .alarm_min_t (alarm_min_t),
  .alarm_min_u (alarm_min_u),
  .sec_t       (sec_t),
  .sec_u       (sec_u),
  .min_t       (min_t),
  .min_u       (min_u),
  .hr_t        (hr_t),
  .hr_u        (hr_u),
  .pm          (pm),
  .alarm       (alarm),
  .min_carry   (min_carry),
  .hour_carry  (hour_carry),
  .hour_force  (hour_force)
);

// File: tb/bcd_clock_core_tb.sv
module bcd_clock_core_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       mode12 = 1'b0;
  logic [3:0] alarm_hr_t = 4'd0, alarm_hr_u = 4'd5, alarm_min_t = 4'd3, alarm_min_u = 4'd0;
  logic [3:0] sec_t, sec_u, min_t, min_u, hr_t, hr_u;
  logic       pm, alarm;

  int checks = 0;
  int errors = 0;
  // Reference time in plain integers.
  int m_h, m_m, m_s;
  bit m_pm;

  always #4 clk = ~clk;

  bcd_clock_core u_dut (
    .clk(clk), .rst(rst), .tick(tick), .mode12(mode12),
    .alarm_hr_t(alarm_hr_t), .alarm_hr_u(alarm_hr_u),
    .alarm_min_t(alarm_min_t), .alarm_min_u(alarm_min_u),
    .sec_t(sec_t), .sec_u(sec_u), .min_t(min_t), .min_u(min_u),
    .hr_t(hr_t), .hr_u(hr_u), .pm(pm), .alarm(alarm)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int dec2(input logic [3:0] t, input logic [3:0] u);
    return int'(t) * 10 + int'(u);
  endfunction

  function automatic bit exp_alarm();
    if (alarm_hr_t > 9 || alarm_hr_u > 9 || alarm_min_t > 9 || alarm_min_u > 9) return 1'b0;
    return (dec2(alarm_hr_t, alarm_hr_u) == m_h) && (dec2(alarm_min_t, alarm_min_u) == m_m);
  endfunction

  // Advance the reference by one second, following R3..R7 and R9.
  task automatic model_tick();
    bit hcarry;
    hcarry = 1'b0;
    m_s++;
    if (m_s == 60) begin
      m_s = 0; m_m++;
      if (m_m == 60) begin m_m = 0; hcarry = 1'b1; end
    end
    if (mode12 && (m_h == 0 || m_h > 12)) m_h = 1;
    else if (hcarry) begin
      if (mode12) begin
        if (m_h == 12) m_h = 1;
        else begin m_h++; if (m_h == 12) m_pm = ~m_pm; end
      end else m_h = (m_h + 1) % 24;
    end
  endtask

  task automatic compare_all();
    check(dec2(sec_t, sec_u) == m_s && sec_u <= 9, "R1 seconds", dec2(sec_t, sec_u), m_s);
    check(dec2(min_t, min_u) == m_m && min_u <= 9, "R3 minutes", dec2(min_t, min_u), m_m);
    if (mode12) check(dec2(hr_t, hr_u) == m_h, "R6 hours", dec2(hr_t, hr_u), m_h);
    else        check(dec2(hr_t, hr_u) == m_h, "R5 hours", dec2(hr_t, hr_u), m_h);
    check(pm == m_pm, "R7 pm", pm, m_pm);
    check(alarm == exp_alarm(), "R10 alarm", alarm, exp_alarm());
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk); @(negedge clk);
      model_tick();
      compare_all();
    end
    tick = 1'b0;
  endtask

  task automatic do_reset(input bit m12);
    @(negedge clk);
    rst = 1'b1; mode12 = m12; tick = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_s = 0; m_m = 0; m_pm = 1'b0; m_h = m12 ? 12 : 0;
    check(dec2(sec_t, sec_u) == 0 && dec2(min_t, min_u) == 0, "R8 reset mm:ss",
          dec2(min_t, min_u) * 100 + dec2(sec_t, sec_u), 0);
    check(dec2(hr_t, hr_u) == m_h, "R8 reset hour", dec2(hr_t, hr_u), m_h);
    check(pm == 1'b0, "R8 reset pm", pm, 0);
  endtask

  task automatic test_hold_r2();
    run_ticks(7);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      check(dec2(sec_t, sec_u) == 7, "R2 hold seconds", dec2(sec_t, sec_u), 7);
    end
    compare_all();
  endtask

  task automatic test_alarm_r10_r11();
    // Clock is at 00:00:07; invalid minute units 0xA must not match minute 10.
    alarm_hr_t = 4'd0; alarm_hr_u = 4'd0; alarm_min_t = 4'd0; alarm_min_u = 4'hA;
    run_ticks(600 - 7);
    check(dec2(min_t, min_u) == 10, "R3 minute reached", dec2(min_t, min_u), 10);
    check(alarm == 1'b0, "R11 invalid digit", alarm, 0);
    run_ticks(20);
    check(alarm == 1'b0, "R11 invalid digit mid-minute", alarm, 0);
    alarm_hr_t = 4'd0; alarm_hr_u = 4'd0; alarm_min_t = 4'd1; alarm_min_u = 4'd0;
    @(negedge clk);
    check(alarm == 1'b1, "R10 match", alarm, 1);
    run_ticks(39);
    check(alarm == 1'b1, "R10 held for minute", alarm, 1);
    run_ticks(1);
    check(alarm == 1'b0, "R10 release next minute", alarm, 0);
    alarm_hr_t = 4'd0; alarm_hr_u = 4'd7; alarm_min_t = 4'd0; alarm_min_u = 4'd5;
  endtask

  task automatic test_full_day_r5();
    int left;
    left = 86400 - 660;
    run_ticks(3600 - 660);
    check(dec2(hr_t, hr_u) == 1 && dec2(min_t, min_u) == 0, "R4 hour carry",
          dec2(hr_t, hr_u) * 100 + dec2(min_t, min_u), 100);
    left = left - (3600 - 660);
    run_ticks(left);
    check(dec2(hr_t, hr_u) == 0 && dec2(min_t, min_u) == 0 && dec2(sec_t, sec_u) == 0,
          "R5 day wrap", dec2(hr_t, hr_u), 0);
  endtask

  task automatic test_mode_force_r9();
    @(negedge clk);
    mode12 = 1'b1;
    run_ticks(1);
    check(dec2(hr_t, hr_u) == 1, "R9 forced hour", dec2(hr_t, hr_u), 1);
    check(dec2(sec_t, sec_u) == 1, "R9 seconds still advance", dec2(sec_t, sec_u), 1);
    check(pm == 1'b0, "R9 pm unchanged", pm, 0);
  endtask

  task automatic test_half_day_r6_r7();
    do_reset(1'b1);
    run_ticks(3600);
    check(dec2(hr_t, hr_u) == 1, "R6 12 to 01", dec2(hr_t, hr_u), 1);
    check(pm == 1'b0, "R7 no flip on 12 to 01", pm, 0);
    run_ticks(10 * 3600);
    check(dec2(hr_t, hr_u) == 11 && pm == 1'b0, "R7 pm before 12", pm, 0);
    run_ticks(3600);
    check(dec2(hr_t, hr_u) == 12, "R6 reach 12", dec2(hr_t, hr_u), 12);
    check(pm == 1'b1, "R7 pm flip at 11 to 12", pm, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    test_hold_r2();
    test_alarm_r10_r11();
    test_full_day_r5();
    test_mode_force_r9();
    test_half_day_r6_r7();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule